// File: doc/BRIEF.md
# Per-Class Alert Escalation Controller

This block runs the escalation side of a single alert class. It counts class alerts in a saturating accumulator. Once the count is past a programmed threshold, the next alert starts an escalation sequence. The sequence also starts when a pending class interrupt is left unhandled for a programmed number of cycles. The sequence walks through four timed phases and then settles in a terminal state.

A single cycle counter serves two jobs: it times the interrupt timeout and it times each escalation phase. Four escalation-enable outputs are decoded from the current phase. Each output has its own programmable phase mapping.

Software-side logic supplies the configuration and the interrupt state. It can abort a sequence with a clear request, provided clearing is enabled. A lock input makes an escalation that has already started impossible to clear.

Top module: `esc_class_ctrl`

## Requirements
- R1: All bits of `alerts_i` are ORed. While `class_en_i` is high, any set bit raises `accu_cnt_o` by exactly one in that cycle. At its maximum value (all ones) the count holds and does not wrap.
- R2: An alert cycle starts escalation when the count before it is at or above `accu_thresh_i` and the state is Idle or Timeout. A threshold of 3 escalates on the 4th alert. A threshold of 0 escalates on the first alert.
- R3: While `irq_pending_i` and `class_en_i` are high and `timeout_cyc_i` is nonzero, the block leaves Idle for Timeout with `cyc_cnt_o`=1. It counts up by one per cycle. In the cycle after `cyc_cnt_o` equals `timeout_cyc_i`, it enters Phase0.
- R4: Dropping `irq_pending_i` during Timeout returns the block to Idle with `cyc_cnt_o`=0.
- R5: A `timeout_cyc_i` of 0 keeps the block in Idle however long the interrupt stays pending.
- R6: Phase k lasts max(1, D) cycles, where D = `phase_cyc_i[k*CYC_W +: CYC_W]`. On entry to each phase `cyc_cnt_o` restarts at 1. It then counts up by one per cycle.
- R7: The state is Phase0 in the cycle right after the clock edge that samples the triggering alert or the timeout.
- R8: `esc_en_o[k]` is high exactly while the state is the phase given by `out_map_i[2k+1:2k]`. A map of 8'hE4 gives output k in phase k.
- R9: A clear request (`clr_req_i` high with `clr_en_i` high) zeroes the accumulator and returns the state to Idle with `cyc_cnt_o`=0. With `clr_en_i` low the request has no effect.
- R10: While `lock_i` is high, a clear request is ignored once the state is a phase or Terminal. The accumulator then keeps its value.
- R11: An alert trigger during Timeout moves the block to Phase0 with `cyc_cnt_o`=1, whatever the timeout count is.
- R12: After Phase3 the block enters Terminal with `cyc_cnt_o`=0 and all escalation outputs low. It stays there until a permitted clear.
- R13: After reset the state is Idle, both counters are 0 and all escalation outputs are low.
- R14: With `class_en_i` low, alerts do not count and the timeout does not start.

State encoding on `state_o`:

| State | Value |
|---|---|
| Idle | 0 |
| Timeout | 1 |
| Terminal | 3 |
| Phase0 | 4 |
| Phase1 | 5 |
| Phase2 | 6 |
| Phase3 | 7 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alerts_i | input | NUM_ALERTS | Alert triggers assigned to this class |
| irq_pending_i | input | 1 | Class interrupt state bit |
| class_en_i | input | 1 | Class enable |
| lock_i | input | 1 | Makes a started escalation unclearable |
| clr_req_i | input | 1 | Clear request |
| clr_en_i | input | 1 | Clear permission |
| accu_thresh_i | input | ACCU_W | Accumulation threshold |
| timeout_cyc_i | input | CYC_W | Interrupt timeout in cycles, 0 disables |
| phase_cyc_i | input | 4*CYC_W | Four phase durations, phase k at bits k*CYC_W |
| out_map_i | input | 8 | Phase mapping, 2 bits per escalation output |
| state_o | output | 3 | Current state (encoding above) |
| cyc_cnt_o | output | CYC_W | Shared timeout / phase cycle counter |
| accu_cnt_o | output | ACCU_W | Alert accumulation count |
| esc_en_o | output | 4 | Escalation enables |

## Verification
The embedded properties assume the configuration inputs behave as register values. They are sampled on each edge and may change at any cycle. They also assume that reset is applied before any stimulus.

The bench changes inputs only between clock edges, well after the active edge. It keeps phase durations, timeout and threshold small, so that every phase and timeout boundary is reached many times. Random cycles vary threshold, map, lock and clear permission freely, so the lock and precedence rules meet every state.

// File: rtl/esc_class_pkg.sv
package esc_class_pkg;
   localparam int unsigned NUM_PHASES = 4;
   localparam int unsigned NUM_OUTS   = 4;
   localparam int unsigned MAP_W      = 2;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'b000,
      ST_TIMEOUT  = 3'b001,
      ST_TERMINAL = 3'b011,
      ST_PHASE0   = 3'b100,
      ST_PHASE1   = 3'b101,
      ST_PHASE2   = 3'b110,
      ST_PHASE3   = 3'b111
   } esc_state_e;
endpackage

// File: rtl/esc_accu.sv
module esc_accu #(
   parameter int unsigned NUM_ALERTS = 4,
   parameter int unsigned ACCU_W     = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_ALERTS-1:0] alerts_i,
   input  logic                  en_i,
   input  logic                  clr_i,
   input  logic [ACCU_W-1:0]     thresh_i,
   output logic [ACCU_W-1:0]     cnt_o,
   output logic                  hit_o
);
   localparam logic [ACCU_W-1:0] CntMax = {ACCU_W{1'b1}};

   if (ACCU_W < 1 || ACCU_W > 32) begin : g_bad_w
      $error("esc_accu: ACCU_W out of range");
   end
   if (NUM_ALERTS < 1) begin : g_bad_n
      $error("esc_accu: NUM_ALERTS must be at least 1");
   end

   logic any_alert;
   if (NUM_ALERTS == 1) begin : g_single
      assign any_alert = alerts_i[0];
   end else begin : g_multi
      assign any_alert = |alerts_i;
   end

   logic             inc;
   logic [ACCU_W-1:0] cnt_q;

   assign inc = en_i & any_alert;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (clr_i)                cnt_q <= '0;
      else if (inc && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
   assign hit_o = inc & (cnt_q >= thresh_i);

   p_no_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_q) == CntMax && !$past(clr_i)) |-> cnt_q == CntMax);
   p_step_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == ACCU_W'($past(cnt_q) + 1'b1)));
   p_gated_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/esc_phase_fsm.sv
module esc_phase_fsm
   import esc_class_pkg::*;
#(
   parameter int unsigned CYC_W = 32
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        hit_i,
   input  logic                        irq_i,
   input  logic                        en_i,
   input  logic                        clr_i,
   input  logic [CYC_W-1:0]            timeout_i,
   input  logic [NUM_PHASES*CYC_W-1:0] phase_cyc_i,
   output esc_state_e                  state_o,
   output logic [CYC_W-1:0]            cnt_o
);
   if (CYC_W < 2 || CYC_W > 32) begin : g_bad_w
      $error("esc_phase_fsm: CYC_W out of range");
   end

   localparam logic [CYC_W-1:0] CntOne = CYC_W'(1);

   esc_state_e       state_q, state_d;
   logic [CYC_W-1:0] cnt_q, cnt_d;
   logic [CYC_W-1:0] cur_dur;
   logic             tmo_arm;

   assign tmo_arm = en_i & irq_i & (timeout_i != '0);
   assign cur_dur = phase_cyc_i[state_q[1:0]*CYC_W +: CYC_W];

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (clr_i) begin
         state_d = ST_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (hit_i) begin
                  state_d = ST_PHASE0;
                  cnt_d   = CntOne;
               end else if (tmo_arm) begin
                  state_d = ST_TIMEOUT;
                  cnt_d   = CntOne;
               end
            end
            ST_TIMEOUT: begin
               if (hit_i) begin
                  state_d = ST_PHASE0;
                  cnt_d   = CntOne;
               end else if (!tmo_arm) begin
                  state_d = ST_IDLE;
                  cnt_d   = '0;
               end else if (cnt_q >= timeout_i) begin
                  state_d = ST_PHASE0;
                  cnt_d   = CntOne;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_PHASE0, ST_PHASE1, ST_PHASE2, ST_PHASE3: begin
               if (cnt_q >= cur_dur) begin
                  if (state_q == ST_PHASE3) begin
                     state_d = ST_TERMINAL;
                     cnt_d   = '0;
                  end else begin
                     state_d = esc_state_e'(state_q + 3'd1);
                     cnt_d   = CntOne;
                  end
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_TERMINAL: ;
            default: begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o = state_q;
   assign cnt_o   = cnt_q;

   p_p0_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_PHASE0 && $past(state_q) != ST_PHASE0) |->
      ($past(state_q) == ST_IDLE || $past(state_q) == ST_TIMEOUT));
   p_phase_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[2] && state_q != $past(state_q)) |-> cnt_q == CntOne);
   p_tmo_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_TIMEOUT) |-> $past(irq_i));
   p_term_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_TERMINAL && !clr_i) |=> (state_q == ST_TERMINAL && cnt_q == '0));
endmodule

// File: rtl/esc_out_map.sv
module esc_out_map
   import esc_class_pkg::*;
(
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  esc_state_e                state_i,
   input  logic [NUM_OUTS*MAP_W-1:0] map_i,
   output logic [NUM_OUTS-1:0]       esc_o
);
   logic in_phase;
   assign in_phase = state_i[2];

   for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
      assign esc_o[k] = in_phase & (state_i[1:0] == map_i[k*MAP_W +: MAP_W]);
   end

   p_phase_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (esc_o != '0) |-> in_phase);
endmodule

// File: rtl/esc_class_ctrl.sv
module esc_class_ctrl
   import esc_class_pkg::*;
#(
   parameter int unsigned NUM_ALERTS = 4,
   parameter int unsigned ACCU_W     = 16,
   parameter int unsigned CYC_W      = 32
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [NUM_ALERTS-1:0]   alerts_i,
   input  logic                    irq_pending_i,
   input  logic                    class_en_i,
   input  logic                    lock_i,
   input  logic                    clr_req_i,
   input  logic                    clr_en_i,
   input  logic [ACCU_W-1:0]       accu_thresh_i,
   input  logic [CYC_W-1:0]        timeout_cyc_i,
   input  logic [4*CYC_W-1:0]      phase_cyc_i,
   input  logic [7:0]              out_map_i,
   output logic [2:0]              state_o,
   output logic [CYC_W-1:0]        cyc_cnt_o,
   output logic [ACCU_W-1:0]       accu_cnt_o,
   output logic [3:0]              esc_en_o
);
   esc_state_e state;
   logic       escalating;
   logic       clr_eff;
   logic       hit;

   assign escalating = state[2] | (state == ST_TERMINAL);
   assign clr_eff    = clr_req_i & clr_en_i & ~(lock_i & escalating);

   esc_accu #(
      .NUM_ALERTS (NUM_ALERTS),
      .ACCU_W     (ACCU_W)
   ) u_accu (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alerts_i (alerts_i),
      .en_i     (class_en_i),
      .clr_i    (clr_eff),
      .thresh_i (accu_thresh_i),
      .cnt_o    (accu_cnt_o),
      .hit_o    (hit)
   );

   esc_phase_fsm #(
      .CYC_W (CYC_W)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hit_i       (hit),
      .irq_i       (irq_pending_i),
      .en_i        (class_en_i),
      .clr_i       (clr_eff),
      .timeout_i   (timeout_cyc_i),
      .phase_cyc_i (phase_cyc_i),
      .state_o     (state),
      .cnt_o       (cyc_cnt_o)
   );

   esc_out_map u_map (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .state_i (state),
      .map_i   (out_map_i),
      .esc_o   (esc_en_o)
   );

   assign state_o = state;

   p_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_i && (state_o[2] || state_o == 3'b011)) |=> (state_o[2] || state_o == 3'b011));
   p_clear_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_req_i && clr_en_i && !lock_i) |=> (state_o == 3'b000 && accu_cnt_o == '0));
endmodule

// File: tb/esc_class_ctrl_bench.sv
`timescale 1ns/1ps
module esc_class_ctrl_bench;
   localparam int NA = 3;
   localparam int AW = 6;
   localparam int CW = 12;
   localparam logic [AW-1:0] AMAX = {AW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NA-1:0] alerts = '0;
   logic          irq = 1'b0, en = 1'b1, lock = 1'b0, clr = 1'b0, clr_en = 1'b1;
   logic [AW-1:0] thr = '0;
   logic [CW-1:0] tmo = '0;
   logic [CW-1:0] dur [4];
   logic [7:0]    map = 8'hE4;
   logic [2:0]    st;
   logic [CW-1:0] cyc;
   logic [AW-1:0] acc;
   logic [3:0]    esc;

   int n_chk = 0, n_fail = 0;
   logic [2:0]    m_st = 3'd0;
   logic [CW-1:0] m_cyc = '0;
   logic [AW-1:0] m_acc = '0;

   always #4 clk = ~clk;

   esc_class_ctrl #(.NUM_ALERTS(NA), .ACCU_W(AW), .CYC_W(CW)) u_esc_class_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .alerts_i(alerts), .irq_pending_i(irq),
      .class_en_i(en), .lock_i(lock), .clr_req_i(clr), .clr_en_i(clr_en),
      .accu_thresh_i(thr), .timeout_cyc_i(tmo),
      .phase_cyc_i({dur[3], dur[2], dur[1], dur[0]}), .out_map_i(map),
      .state_o(st), .cyc_cnt_o(cyc), .accu_cnt_o(acc), .esc_en_o(esc));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_esc(input logic [2:0] s, input logic [7:0] mp);
      logic [3:0] r = '0;
      for (int k = 0; k < 4; k++)
         r[k] = s[2] && (s[1:0] == mp[2*k +: 2]);
      return r;
   endfunction

   task automatic step();
      logic [2:0]    ns = m_st;
      logic [CW-1:0] nc = m_cyc;
      logic [AW-1:0] na = m_acc;
      logic esc_on = m_st[2] || m_st == 3'd3;
      logic ce = clr && clr_en && !(lock && esc_on);
      logic trig = en && (alerts != 0);
      logic fire = trig && (m_acc >= thr);
      logic arm = en && irq && (tmo != 0);
      if (ce) na = '0;
      else if (trig && m_acc != AMAX) na = m_acc + 1'b1;
      if (ce) begin ns = 3'd0; nc = '0; end
      else if (m_st == 3'd0 || m_st == 3'd1) begin
         if (fire) begin ns = 3'd4; nc = 1; end
         else if (m_st == 3'd0) begin if (arm) begin ns = 3'd1; nc = 1; end end
         else if (!arm) begin ns = 3'd0; nc = '0; end
         else if (m_cyc >= tmo) begin ns = 3'd4; nc = 1; end
         else nc = m_cyc + 1'b1;
      end else if (m_st[2]) begin
         if (m_cyc >= dur[m_st[1:0]]) begin
            if (m_st == 3'd7) begin ns = 3'd3; nc = '0; end
            else begin ns = m_st + 3'd1; nc = 1; end
         end else nc = m_cyc + 1'b1;
      end
      @(posedge clk);
      m_st = ns; m_cyc = nc; m_acc = na;
      #2;
      chk("R6 state vs model", st, m_st);
      chk("R6 cycle count vs model", cyc, m_cyc);
      chk("R1 accumulator vs model", acc, m_acc);
      chk("R8 escalation outputs vs model", esc, exp_esc(m_st, map));
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_clear();
      lock = 1'b0; clr_en = 1'b1; clr = 1'b1; step(); clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R13 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(1234);
      dur[0] = 2; dur[1] = 0; dur[2] = 1; dur[3] = 3;
      thr = 3;
      repeat (3) @(posedge clk);
      #2;
      chk("R13 reset state", st, 0);
      chk("R13 reset accumulator", acc, 0);
      chk("R13 reset escalation", esc, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2;

      // R1: three simultaneous alerts count once
      alerts = 3'b111; step(); alerts = '0;
      chk("R1 ORed alerts count once", acc, 1);
      alerts = 3'b010; step(); step(); alerts = '0; step();
      chk("R2 at threshold no escalation yet", st, 0);
      alerts = 3'b001; step(); alerts = '0;
      chk("R7 Phase0 one cycle after trigger", st, 4);
      chk("R6 count starts at 1", cyc, 1);
      chk("R8 default map phase0", esc, 4'b0001);
      step(); step();
      chk("R6 phase0 two cycles", st, 5);
      chk("R8 default map phase1", esc, 4'b0010);
      step();
      chk("R6 zero duration lasts one cycle", st, 6);
      step(); steps(3);
      chk("R12 terminal reached", st, 3);
      chk("R12 terminal count zero", cyc, 0);
      chk("R12 terminal outputs low", esc, 0);
      steps(5);
      chk("R12 terminal sticky", st, 3);
      clr_en = 1'b0; clr = 1'b1; step(); clr = 1'b0; clr_en = 1'b1;
      chk("R9 clear without permission ignored", st, 3);
      chk("R9 accumulator kept", acc, 4);
      do_clear();
      chk("R9 clear to idle", st, 0);
      chk("R9 clear accumulator", acc, 0);

      // R3: timeout path
      tmo = 4; irq = 1'b1; step();
      chk("R3 timeout entered", st, 1);
      steps(3);
      chk("R3 timeout count", cyc, 4);
      step();
      chk("R3 timeout escalates", st, 4);
      irq = 1'b0; do_clear();
      irq = 1'b1; steps(2); irq = 1'b0; step();
      chk("R4 irq drop returns idle", st, 0);
      chk("R4 irq drop count zero", cyc, 0);
      tmo = 0; irq = 1'b1; steps(10);
      chk("R5 zero timeout disabled", st, 0);

      // R11: trigger wins over timeout
      tmo = 6; thr = 0; step(); step();
      chk("R11 in timeout", st, 1);
      alerts = 3'b100; step(); alerts = '0;
      chk("R11 escalation over timeout", st, 4);
      chk("R11 count restarted", cyc, 1);
      irq = 1'b0;

      // R10: lock blocks clear
      lock = 1'b1; clr = 1'b1; step(); clr = 1'b0;
      chk("R10 locked clear ignored", st[2], 1);
      chk("R10 accumulator kept", acc, 1);
      lock = 1'b0; do_clear();
      chk("R10 unlocked clear works", st, 0);

      // R14: disabled class
      en = 1'b0; alerts = 3'b111; irq = 1'b1; tmo = 2; steps(4);
      alerts = '0; irq = 1'b0;
      chk("R14 no count when disabled", acc, 0);
      chk("R14 no state change when disabled", st, 0);
      en = 1'b1;

      // R8: all outputs on phase 2
      map = 8'hAA; thr = 0; alerts = 3'b001; step(); alerts = '0;
      chk("R8 phase0 with map AA", esc, 0);
      steps(3);
      chk("R8 phase2 all outputs", esc, 4'b1111);
      do_clear(); map = 8'hE4;

      // R1: saturation
      thr = AMAX; alerts = 3'b001; steps(70); alerts = '0;
      chk("R1 saturated", acc, AMAX);
      do_clear();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         alerts = (($urandom % 4) == 0) ? NA'($urandom) : '0;
         if (($urandom % 50) == 0) irq = ~irq;
         en     = ($urandom % 16) != 0;
         clr    = ($urandom % 40) == 0;
         clr_en = ($urandom % 3) != 0;
         if (($urandom % 100) == 0) lock = ~lock;
         if (($urandom % 60) == 0) begin
            thr = AW'($urandom % 8);
            tmo = CW'($urandom % 9);
            map = 8'($urandom);
            for (int k = 0; k < 4; k++) dur[k] = CW'($urandom % 6);
         end
         step();
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule